// File: doc/BRIEF.md
# Trap Freeze and Monitor Controller

This block holds the trap-related control state of a small pipelined processor core. It tracks the last three program-counter values in a main history chain and a second, shadow chain. It also keeps a freeze bit and a monitor-active bit. When a trap is taken, the block freezes the main history and suppresses ALU-flag and channel-register writes. It also issues a one-cycle fetch redirect, either to the trap's own vector or, for a monitor trap, to the fixed monitor entry in instruction-ROM space.

A trap is a monitor trap when it is synchronous and the monitor-enable input is high. Asynchronous traps never enter monitor mode. These are timer interrupts and external trap or interrupt request lines, and the core marks them with `trap_async`. While monitor mode is active the shadow chain stops as well. This lets an interrupt-return issued from monitor mode restart the frozen code from the shadow history. An interrupt-return issued outside monitor mode resumes from the main history.

The control state is a three-state machine:
- RUN: normal execution.
- FROZEN: a trap was taken, monitor mode is not active.
- MONITOR: a monitor trap was taken.

Its transitions are:
- TAKE_TRAP: RUN or FROZEN go to FROZEN on a non-monitor trap.
- TAKE_MON: RUN, FROZEN or MONITOR go to MONITOR on a monitor trap.
- TRAP_IN_MON: an asynchronous or non-monitor trap leaves MONITOR in MONITOR.
- RETURN: FROZEN or MONITOR go to RUN on an interrupt-return.

Top module: `trap_freeze_ctl`

## Requirements
- R1: After reset the state is RUN: `frozen`=0, `monitor`=0, `reason`=0, `redir_valid`=0, and both histories are all zero.
- R2: On each clock with `pc_adv`=1 and `frozen`=0, the main history shifts. Entry 0 (bits [AW-1:0]) takes `pc_bus`, entry 1 takes entry 0, and entry 2 takes entry 1. While `frozen`=1 the main history holds.
- R3: The shadow history shifts the same way whenever `monitor`=0, including while `frozen`=1. While `monitor`=1 it holds.
- R4: `flag_we` equals `flag_we_in` when `frozen`=0 and is 0 when `frozen`=1.
- R5: `chan_we` equals `chan_we_in` when `frozen`=0 and is 0 when `frozen`=1.
- R6: A synchronous trap (`trap_async`=0) with `mon_enable`=1 has the following effect in the next cycle. `redir_valid`=1, `redir_addr`=16, `redir_rom`=1, `frozen`=1, `monitor`=1, and `reason` equals the `trap_vec` that came with the trap.
- R7: An asynchronous trap (`trap_async`=1) never sets `monitor`, even with `mon_enable`=1. In the next cycle `redir_valid`=1, `redir_addr` is `trap_vec` zero-extended, `redir_rom`=0 and `frozen`=1, and `reason` is unchanged.
- R8: A synchronous trap with `mon_enable`=0 takes the same normal path as R7.
- R9: An interrupt-return in MONITOR gives, in the next cycle, `redir_valid`=1, `redir_addr` equal to shadow entry 0, `redir_rom`=0, `frozen`=0 and `monitor`=0.
- R10: An interrupt-return in FROZEN gives, in the next cycle, `redir_valid`=1, `redir_addr` equal to main entry 0, `redir_rom`=0 and `frozen`=0.
- R11: An interrupt-return in RUN is ignored: no redirect, and the state stays RUN.
- R12: When `trap_req` and `iret` are both high, the trap is taken and the return is ignored.
- R13: A non-monitor trap taken in MONITOR redirects to its vector with `redir_rom`=0. `monitor` stays 1 and `reason` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_bus | input | AW | Program-counter bus value |
| pc_adv | input | 1 | PC bus carries a new value this cycle |
| trap_req | input | 1 | Take a trap this cycle |
| trap_async | input | 1 | Trap comes from an asynchronous source |
| trap_vec | input | 8 | Trap vector number / cause code |
| mon_enable | input | 1 | Monitor mode enabled for synchronous traps |
| iret | input | 1 | Interrupt-return executed |
| flag_we_in | input | 1 | Requested ALU flag write |
| chan_we_in | input | 1 | Requested channel register write |
| flag_we | output | 1 | Gated ALU flag write enable |
| chan_we | output | 1 | Gated channel register write enable |
| frozen | output | 1 | Freeze state active |
| monitor | output | 1 | Monitor mode active |
| reason | output | 8 | Cause code of the last monitor trap |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | AW | Fetch redirect address |
| redir_rom | output | 1 | Redirect targets instruction-ROM space |
| pc_hist | output | 3*AW | Main history, entry 0 in the low bits |
| shadow_hist | output | 3*AW | Shadow history, entry 0 in the low bits |

## Verification
Some rules are checked on every cycle:
- the write-enable gating;
- the holding of the main history while frozen and of the shadow history in monitor mode;
- monitor mode never being active without freeze;
- asynchronous traps never reaching monitor mode;
- every ROM-space redirect pointing at 16 with monitor active;
- a return in RUN never redirecting.

Other behaviour needs the bench's directed scenarios. These are the exact redirect targets chosen by a return from each state, the reason code latched and kept across later traps, the shadow history continuing to move while only frozen, and the priority of a trap over a simultaneous return.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_FROZEN  = 2'd1,
        ST_MONITOR = 2'd2
    } mode_e;
    localparam int VEC_W = 8;
endpackage

// File: rtl/tfc_pc_chain.sv
module tfc_pc_chain #(
    parameter int AW    = 32,
    parameter int DEPTH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                hold,
    input  logic [AW-1:0]       pc_in,
    output logic [DEPTH*AW-1:0] hist
);
    logic [AW-1:0] stage [DEPTH];
    logic          shift_en;

    assign shift_en = adv && !hold;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        stage[i] <= '0;
                else if (shift_en) stage[i] <= pc_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        stage[i] <= '0;
                else if (shift_en) stage[i] <= stage[i-1];
            end
        end
        assign hist[i*AW +: AW] = stage[i];
    end
endmodule

// File: rtl/tfc_mode_fsm.sv
module tfc_mode_fsm
    import tfc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MON_VEC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic             trap_async,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             mon_enable,
    input  logic             iret,
    input  logic [AW-1:0]    main_top,
    input  logic [AW-1:0]    shadow_top,
    output logic             fz,
    output logic             mm,
    output logic [VEC_W-1:0] reason,
    output logic             redir_valid,
    output logic [AW-1:0]    redir_addr,
    output logic             redir_rom
);
    mode_e state_q, state_d;
    logic  mon_take;
    logic  rv_d, rom_d;
    logic [AW-1:0] addr_d;

    assign mon_take = trap_req && !trap_async && mon_enable;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (trap_req) state_d = mon_take ? ST_MONITOR : ST_FROZEN;
            end
            ST_FROZEN: begin
                if (trap_req)  state_d = mon_take ? ST_MONITOR : ST_FROZEN;
                else if (iret) state_d = ST_RUN;
            end
            ST_MONITOR: begin
                if (trap_req)  state_d = ST_MONITOR;
                else if (iret) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // redirect selection
    always_comb begin
        rv_d   = 1'b0;
        rom_d  = 1'b0;
        addr_d = '0;
        if (trap_req) begin
            rv_d = 1'b1;
            if (mon_take) begin
                addr_d = AW'(MON_VEC);
                rom_d  = 1'b1;
            end else begin
                addr_d = AW'(trap_vec);
            end
        end else if (iret && state_q != ST_RUN) begin
            rv_d   = 1'b1;
            addr_d = (state_q == ST_MONITOR) ? shadow_top : main_top;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            redir_rom   <= 1'b0;
            reason      <= '0;
        end else begin
            redir_valid <= rv_d;
            redir_addr  <= addr_d;
            redir_rom   <= rom_d;
            if (mon_take) reason <= trap_vec;
        end
    end

    assign fz = (state_q != ST_RUN);
    assign mm = (state_q == ST_MONITOR);
endmodule

// File: rtl/trap_freeze_ctl.sv
module trap_freeze_ctl
    import tfc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int HIST    = 3,
    parameter int MON_VEC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      pc_bus,
    input  logic               pc_adv,
    input  logic               trap_req,
    input  logic               trap_async,
    input  logic [VEC_W-1:0]   trap_vec,
    input  logic               mon_enable,
    input  logic               iret,
    input  logic               flag_we_in,
    input  logic               chan_we_in,
    output logic               flag_we,
    output logic               chan_we,
    output logic               frozen,
    output logic               monitor,
    output logic [VEC_W-1:0]   reason,
    output logic               redir_valid,
    output logic [AW-1:0]      redir_addr,
    output logic               redir_rom,
    output logic [HIST*AW-1:0] pc_hist,
    output logic [HIST*AW-1:0] shadow_hist
);
    logic fz, mm;

    tfc_pc_chain #(.AW(AW), .DEPTH(HIST)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pc_adv),
        .hold  (fz),
        .pc_in (pc_bus),
        .hist  (pc_hist)
    );

    tfc_pc_chain #(.AW(AW), .DEPTH(HIST)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pc_adv),
        .hold  (mm),
        .pc_in (pc_bus),
        .hist  (shadow_hist)
    );

    tfc_mode_fsm #(.AW(AW), .MON_VEC(MON_VEC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_req    (trap_req),
        .trap_async  (trap_async),
        .trap_vec    (trap_vec),
        .mon_enable  (mon_enable),
        .iret        (iret),
        .main_top    (pc_hist[AW-1:0]),
        .shadow_top  (shadow_hist[AW-1:0]),
        .fz          (fz),
        .mm          (mm),
        .reason      (reason),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .redir_rom   (redir_rom)
    );

    assign flag_we = flag_we_in && !fz;
    assign chan_we = chan_we_in && !fz;
    assign frozen  = fz;
    assign monitor = mm;
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
    parameter int AW      = 32,
    parameter int HIST    = 3,
    parameter int MON_VEC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_req,
    input logic               trap_async,
    input logic               iret,
    input logic               flag_we_in,
    input logic               chan_we_in,
    input logic               flag_we,
    input logic               chan_we,
    input logic               frozen,
    input logic               monitor,
    input logic               redir_valid,
    input logic [AW-1:0]      redir_addr,
    input logic               redir_rom,
    input logic [HIST*AW-1:0] pc_hist,
    input logic [HIST*AW-1:0] shadow_hist
);
    p_main_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(pc_hist));

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        monitor |=> $stable(shadow_hist));

    p_flag_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen |-> !flag_we) and ((!frozen && flag_we_in) |-> flag_we));

    p_chan_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen |-> !chan_we) and ((!frozen && chan_we_in) |-> chan_we));

    p_mon_implies_fz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        monitor |-> frozen);

    p_rom_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_rom) |-> (redir_addr == AW'(MON_VEC) && monitor));

    p_async_no_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_async && !monitor) |=> !monitor);

    p_iret_run_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iret && !trap_req && !frozen) |=> (!redir_valid && !frozen));
endmodule

bind trap_freeze_ctl tfc_checker #(.AW(AW), .HIST(HIST), .MON_VEC(MON_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_req    (trap_req),
    .trap_async  (trap_async),
    .iret        (iret),
    .flag_we_in  (flag_we_in),
    .chan_we_in  (chan_we_in),
    .flag_we     (flag_we),
    .chan_we     (chan_we),
    .frozen      (frozen),
    .monitor     (monitor),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .redir_rom   (redir_rom),
    .pc_hist     (pc_hist),
    .shadow_hist (shadow_hist)
);

// File: tb/tb_trap_freeze_ctl.sv
module tb_trap_freeze_ctl;
    localparam int AW = 32;
    localparam int HIST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] pc_bus = '0;
    logic pc_adv = 1'b0, trap_req = 1'b0, trap_async = 1'b0;
    logic [7:0] trap_vec = '0;
    logic mon_enable = 1'b0, iret = 1'b0, flag_we_in = 1'b0, chan_we_in = 1'b0;
    logic flag_we, chan_we, frozen, monitor, redir_valid, redir_rom;
    logic [7:0] reason;
    logic [AW-1:0] redir_addr;
    logic [HIST*AW-1:0] pc_hist, shadow_hist;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trap_freeze_ctl #(.AW(AW), .HIST(HIST)) dut (
        .clk(clk), .rst_n(rst_n), .pc_bus(pc_bus), .pc_adv(pc_adv),
        .trap_req(trap_req), .trap_async(trap_async), .trap_vec(trap_vec),
        .mon_enable(mon_enable), .iret(iret), .flag_we_in(flag_we_in),
        .chan_we_in(chan_we_in), .flag_we(flag_we), .chan_we(chan_we),
        .frozen(frozen), .monitor(monitor), .reason(reason),
        .redir_valid(redir_valid), .redir_addr(redir_addr), .redir_rom(redir_rom),
        .pc_hist(pc_hist), .shadow_hist(shadow_hist)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        pc_adv = 1'b0; trap_req = 1'b0; trap_async = 1'b0; iret = 1'b0;
    endtask

    task automatic push_pc(input logic [AW-1:0] v);
        pc_bus = v; pc_adv = 1'b1;
        step();
        clear_inputs();
    endtask

    task automatic take_trap(input logic async_src, input logic [7:0] vec);
        trap_req = 1'b1; trap_async = async_src; trap_vec = vec;
        step();
        clear_inputs();
    endtask

    task automatic do_iret();
        iret = 1'b1;
        step();
        clear_inputs();
    endtask

    task automatic t_reset();
        chk("R1 frozen", 96'(frozen), 96'd0);
        chk("R1 monitor", 96'(monitor), 96'd0);
        chk("R1 reason", 96'(reason), 96'd0);
        chk("R1 redir_valid", 96'(redir_valid), 96'd0);
        chk("R1 pc_hist", 96'(pc_hist), 96'd0);
        chk("R1 shadow_hist", 96'(shadow_hist), 96'd0);
    endtask

    task automatic t_history();
        push_pc(32'h100); push_pc(32'h104); push_pc(32'h108);
        chk("R2 main shift", 96'(pc_hist), {32'h100, 32'h104, 32'h108});
        chk("R3 shadow shift", 96'(shadow_hist), {32'h100, 32'h104, 32'h108});
        flag_we_in = 1'b1; chan_we_in = 1'b1; #1;
        chk("R4 flag pass", 96'(flag_we), 96'd1);
        chk("R5 chan pass", 96'(chan_we), 96'd1);
        flag_we_in = 1'b0; chan_we_in = 1'b0;
    endtask

    task automatic t_iret_in_run();
        do_iret();
        chk("R11 no redirect", 96'(redir_valid), 96'd0);
        chk("R11 stays run", 96'(frozen), 96'd0);
    endtask

    task automatic t_async_trap();
        mon_enable = 1'b1;
        take_trap(1'b1, 8'h21);
        chk("R7 redir_valid", 96'(redir_valid), 96'd1);
        chk("R7 addr", 96'(redir_addr), 96'h21);
        chk("R7 rom", 96'(redir_rom), 96'd0);
        chk("R7 frozen", 96'(frozen), 96'd1);
        chk("R7 no monitor", 96'(monitor), 96'd0);
        chk("R7 reason kept", 96'(reason), 96'd0);
        flag_we_in = 1'b1; chan_we_in = 1'b1; #1;
        chk("R4 flag gated", 96'(flag_we), 96'd0);
        chk("R5 chan gated", 96'(chan_we), 96'd0);
        flag_we_in = 1'b0; chan_we_in = 1'b0;
        push_pc(32'h200);
        chk("R2 main held", 96'(pc_hist), {32'h100, 32'h104, 32'h108});
        chk("R3 shadow moves", 96'(shadow_hist), {32'h104, 32'h108, 32'h200});
        do_iret();
        chk("R10 redir_valid", 96'(redir_valid), 96'd1);
        chk("R10 addr main", 96'(redir_addr), 96'h108);
        chk("R10 unfrozen", 96'(frozen), 96'd0);
    endtask

    task automatic t_sync_no_mon();
        mon_enable = 1'b0;
        take_trap(1'b0, 8'h05);
        chk("R8 addr", 96'(redir_addr), 96'h05);
        chk("R8 rom", 96'(redir_rom), 96'd0);
        chk("R8 frozen", 96'(frozen), 96'd1);
        chk("R8 no monitor", 96'(monitor), 96'd0);
        do_iret();
        chk("R10 addr again", 96'(redir_addr), 96'h108);
    endtask

    task automatic t_monitor();
        mon_enable = 1'b1;
        take_trap(1'b0, 8'h3C);
        chk("R6 redir_valid", 96'(redir_valid), 96'd1);
        chk("R6 addr", 96'(redir_addr), 96'd16);
        chk("R6 rom", 96'(redir_rom), 96'd1);
        chk("R6 frozen", 96'(frozen), 96'd1);
        chk("R6 monitor", 96'(monitor), 96'd1);
        chk("R6 reason", 96'(reason), 96'h3C);
        push_pc(32'h300);
        chk("R3 shadow held", 96'(shadow_hist), {32'h104, 32'h108, 32'h200});
        chk("R2 main held mon", 96'(pc_hist), {32'h100, 32'h104, 32'h108});
        take_trap(1'b1, 8'h40);
        chk("R13 addr", 96'(redir_addr), 96'h40);
        chk("R13 rom", 96'(redir_rom), 96'd0);
        chk("R13 monitor kept", 96'(monitor), 96'd1);
        chk("R13 reason kept", 96'(reason), 96'h3C);
        do_iret();
        chk("R9 redir_valid", 96'(redir_valid), 96'd1);
        chk("R9 addr shadow", 96'(redir_addr), 96'h200);
        chk("R9 monitor cleared", 96'(monitor), 96'd0);
        chk("R9 unfrozen", 96'(frozen), 96'd0);
    endtask

    task automatic t_collide();
        take_trap(1'b1, 8'h11);
        trap_req = 1'b1; trap_async = 1'b1; trap_vec = 8'h12; iret = 1'b1;
        step();
        clear_inputs();
        chk("R12 still frozen", 96'(frozen), 96'd1);
        chk("R12 trap addr", 96'(redir_addr), 96'h12);
        do_iret();
        chk("R12 released", 96'(frozen), 96'd0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_history();
        t_iret_in_run();
        t_async_trap();
        t_sync_no_mon();
        t_monitor();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule